// File: doc/BRIEF.md
# Crossing History Readback Buffer

The block records a 64-bit threshold-comparison mask, eight reference sets of eight comparison bits each, on every beam crossing, and keeps the eight most recent crossings: the current one and the seven before it. Storage is held in two independent history banks. Timing controls pick which bank records, whether a capture strobe actually shifts a new mask into the history, and which bank is presented to the control bus. This lets one bank keep running while the other stays frozen on the crossing of interest and is read out.

The control bus is read-only. A read is addressed by a 6-bit card address and an 8-bit function address. The function address is laid out as 32n + s, where s selects the reference set and n selects the crossing, with n = 7 being the current crossing and n = 0 the oldest. Read data appears on a registered byte output with an output-enable, and the pad ring combines the two into the bidirectional data lines. Write cycles are accepted on the pins and discarded.

Top module: `hist_readback`

## Requirements
- R1: After reset every stored mask in both banks is zero and the read-data enable is low.
- R2: A capture strobe with shifting enabled pushes the mask into the bank chosen by the write-bank select. Each older entry of that bank moves one step back. The other bank is unchanged.
- R3: A capture strobe with shifting disabled leaves both banks unchanged.
- R4: A read of function address 32n + s (n in bits 7:5, s in bits 2:0, bits 4:3 zero) returns reference set s of the crossing 7 - n captures old, so n = 7 is the newest entry.
- R5: In a returned byte, bit 0 is comparison bit 1 of the set, which is mask bit 8s. Bit 7 is comparison bit 8, which is mask bit 8s + 7.
- R6: A read whose offset within the 32-address group is 8 or more returns 0x00.
- R7: A cycle with a card address other than the strapped CARD_ID, or with the direction set to write, never raises the read-data enable. Write data changes no stored content.
- R8: Read data and its enable are registered. They are valid in the cycle after the clock edge that samples a matching read strobe, and the enable drops in the cycle after the strobe is sampled low.
- R9: The read-bank select is taken only at edges where the bus strobe is low. While the strobe stays high, every read sees the same bank.
- R10: The history is exactly eight deep. The ninth capture into a bank drops the oldest entry, and address group 0 then shows the second capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_in | input | 64 | Comparison mask, set s in bits 8s+7..8s |
| cap_strobe | input | 1 | Input-latch strobe, one per crossing |
| hist_shift | input | 1 | 1: captures shift the history, 0: history held |
| wr_bank_sel | input | 1 | Bank that records captures |
| rd_bank_sel | input | 1 | Bank presented to the bus |
| card_addr | input | 6 | Bus card address |
| func_addr | input | 8 | Bus function address (32n + s) |
| bus_strobe | input | 1 | Bus cycle strobe |
| bus_rd | input | 1 | Direction, 1 = read |
| bus_wdata | input | 8 | Inbound half of the data lines, discarded |
| bus_rdata | output | 8 | Outbound half of the data lines |
| bus_rdata_oe | output | 1 | Drive enable for the data lines |

## Verification
Each bank is filled with masks built by a 64-bit multiplicative hash, so every set byte of every crossing is distinct. Swapped set indices, reversed crossing order, mirrored bit order and a mixed-up bank all show as wrong bytes. Every one of the 256 function addresses is read in both banks. This covers all mapped and unmapped offsets and exposes any decode that ignores an address bit. Separate patterns follow: a ninth capture that must drop the oldest entry, captures with shifting disabled, writes and wrong-card reads with all-ones write data, and a bank-select change made while the strobe stays high. These show that frozen state really is frozen and that a bank swap waits for the strobe to drop.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int unsigned SETS_DEF   = 8;
  localparam int unsigned SETW_DEF   = 8;
  localparam int unsigned DEPTH_DEF  = 8;
  localparam int unsigned GROUP_AW   = 5;   // 32 addresses per crossing group
  localparam int unsigned NBANKS     = 2;

  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic [WIDTH-1:0]       din,
  output logic [DEPTH*WIDTH-1:0] hist
);
  logic [DEPTH*WIDTH-1:0] hist_q, hist_d;

  // slot k holds the mask captured k crossings ago
  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d[WIDTH-1:0] = din;
      for (int k = 1; k < int'(DEPTH); k++) begin
        hist_d[k*WIDTH +: WIDTH] = hist_q[(k-1)*WIDTH +: WIDTH];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/hist_reader.sv
module hist_reader #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned SETS     = 8,
  parameter int unsigned SETW     = 8,
  parameter int unsigned GROUP_AW = 5,
  localparam int unsigned WIDTH   = SETS * SETW,
  localparam int unsigned NW      = $clog2(DEPTH),
  localparam int unsigned AW      = NW + GROUP_AW
) (
  input  logic [DEPTH*WIDTH-1:0] hist,
  input  logic [AW-1:0]          addr,
  output logic [SETW-1:0]        rbyte
);
  logic [NW-1:0]       grp;
  logic [GROUP_AW-1:0] off;
  logic [NW-1:0]       age;
  logic [WIDTH-1:0]    entry;

  assign grp = addr[AW-1:GROUP_AW];
  assign off = addr[GROUP_AW-1:0];
  // group DEPTH-1 is the newest crossing, group 0 the oldest
  assign age = NW'(DEPTH - 1) - grp;

  always_comb begin
    entry = hist[age*WIDTH +: WIDTH];
    rbyte = '0;
    for (int s = 0; s < int'(SETS); s++) begin
      if (off == GROUP_AW'(s)) rbyte = entry[s*SETW +: SETW];
    end
  end
endmodule

// File: rtl/hist_bus_port.sv
module hist_bus_port #(
  parameter int unsigned SETW    = 8,
  parameter logic [5:0]  CARD_ID = 6'h15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      card_addr,
  input  logic            bus_strobe,
  input  logic            bus_rd,
  input  logic [SETW-1:0] lookup,
  output logic [SETW-1:0] rdata,
  output logic            rdata_oe
);
  logic            hit;
  logic [SETW-1:0] rdata_d;
  logic            oe_d;

  assign hit = bus_strobe && bus_rd && (card_addr == CARD_ID);

  always_comb begin
    oe_d    = hit;
    rdata_d = hit ? lookup : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata    <= rdata_d;
      rdata_oe <= oe_d;
    end
  end
endmodule

// File: rtl/hist_readback.sv
module hist_readback #(
  parameter int unsigned SETS    = hist_pkg::SETS_DEF,
  parameter int unsigned SETW    = hist_pkg::SETW_DEF,
  parameter int unsigned DEPTH   = hist_pkg::DEPTH_DEF,
  parameter logic [5:0]  CARD_ID = 6'h15,
  localparam int unsigned WIDTH  = SETS * SETW,
  localparam int unsigned BANK_W = DEPTH * WIDTH,
  localparam int unsigned AW     = $clog2(DEPTH) + hist_pkg::GROUP_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] mask_in,
  input  logic             cap_strobe,
  input  logic             hist_shift,
  input  logic             wr_bank_sel,
  input  logic             rd_bank_sel,
  input  logic [5:0]       card_addr,
  input  logic [AW-1:0]    func_addr,
  input  logic             bus_strobe,
  input  logic             bus_rd,
  input  logic [SETW-1:0]  bus_wdata,
  output logic [SETW-1:0]  bus_rdata,
  output logic             bus_rdata_oe
);
  import hist_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // write data has no destination: the bus is read-only
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  logic [BANK_W-1:0] bank_hist [NBANKS];

  for (genvar b = 0; b < int'(NBANKS); b++) begin : g_bank
    logic shift_here;
    assign shift_here = cap_strobe && hist_shift && (wr_bank_sel == b[0]);
    hist_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .shift_en (shift_here),
      .din      (mask_in),
      .hist     (bank_hist[b])
    );
  end

  // read bank follows its select only between bus cycles
  bank_e rd_bank_q, rd_bank_d;
  always_comb begin
    rd_bank_d = rd_bank_q;
    if (!bus_strobe) rd_bank_d = bank_e'(rd_bank_sel);
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rd_bank_q <= BANK_A;
    else          rd_bank_q <= rd_bank_d;
  end

  logic [BANK_W-1:0] rd_hist;
  assign rd_hist = (rd_bank_q == BANK_B) ? bank_hist[1] : bank_hist[0];

  logic [SETW-1:0] lookup;
  hist_reader #(
    .DEPTH(DEPTH), .SETS(SETS), .SETW(SETW), .GROUP_AW(GROUP_AW)
  ) u_reader (
    .hist  (rd_hist),
    .addr  (func_addr),
    .rbyte (lookup)
  );

  hist_bus_port #(.SETW(SETW), .CARD_ID(CARD_ID)) u_port (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .card_addr  (card_addr),
    .bus_strobe (bus_strobe),
    .bus_rd     (bus_rd),
    .lookup     (lookup),
    .rdata      (bus_rdata),
    .rdata_oe   (bus_rdata_oe)
  );
endmodule

// File: rtl/hist_readback_chk.sv
module hist_readback_chk #(
  parameter int unsigned SETW     = 8,
  parameter int unsigned BANK_W   = 512,
  parameter int unsigned GROUP_AW = 5,
  parameter int unsigned AW       = 8,
  parameter logic [5:0]  CARD_ID  = 6'h15
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              cap_strobe,
  input logic              hist_shift,
  input logic              wr_bank_sel,
  input logic              rd_bank_q,
  input logic [5:0]        card_addr,
  input logic [AW-1:0]     func_addr,
  input logic              bus_strobe,
  input logic              bus_rd,
  input logic [BANK_W-1:0] hist0,
  input logic [BANK_W-1:0] hist1,
  input logic [SETW-1:0]   bus_rdata,
  input logic              bus_rdata_oe
);
  logic rd_hit;
  assign rd_hit = bus_strobe && bus_rd && (card_addr == CARD_ID);

  // R3: no shifting capture -> both banks hold
  a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(cap_strobe && hist_shift) |=> ($stable(hist0) && $stable(hist1)));

  // R2: capture into one bank leaves the other untouched
  a_r2_other_bank_a: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cap_strobe && hist_shift && !wr_bank_sel) |=> $stable(hist1));
  a_r2_other_bank_b: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cap_strobe && hist_shift && wr_bank_sel) |=> $stable(hist0));

  // R7: no matching read -> no drive
  a_r7_no_drive: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_hit |=> !bus_rdata_oe);

  // R8: matching read -> drive next cycle
  a_r8_drive_after_read: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_hit |=> bus_rdata_oe);

  // R6: unmapped offset reads as zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_hit && (func_addr[GROUP_AW-1:3] != '0)) |=> (bus_rdata == '0));

  // R9: read bank frozen while strobe high
  a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_strobe |=> $stable(rd_bank_q));

  // R1: enable low directly after reset release
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_s_n) |-> !bus_rdata_oe);
endmodule

bind hist_readback hist_readback_chk #(
  .SETW(SETW), .BANK_W(BANK_W), .GROUP_AW(hist_pkg::GROUP_AW),
  .AW(AW), .CARD_ID(CARD_ID)
) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .cap_strobe   (cap_strobe),
  .hist_shift   (hist_shift),
  .wr_bank_sel  (wr_bank_sel),
  .rd_bank_q    (rd_bank_q),
  .card_addr    (card_addr),
  .func_addr    (func_addr),
  .bus_strobe   (bus_strobe),
  .bus_rd       (bus_rd),
  .hist0        (bank_hist[0]),
  .hist1        (bank_hist[1]),
  .bus_rdata    (bus_rdata),
  .bus_rdata_oe (bus_rdata_oe)
);

// File: tb/tb_hist_readback.sv
module tb_hist_readback;
  localparam logic [5:0] CARD = 6'h15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] mask_in = '0;
  logic        cap_strobe = 1'b0, hist_shift = 1'b0;
  logic        wr_bank_sel = 1'b0, rd_bank_sel = 1'b0;
  logic [5:0]  card_addr = '0;
  logic [7:0]  func_addr = '0;
  logic        bus_strobe = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference history: model[bank][age]
  logic [63:0] model [2][8];

  always #2 clk = ~clk;

  hist_readback #(.CARD_ID(CARD)) dut (
    .clk(clk), .rst_n(rst_n), .mask_in(mask_in), .cap_strobe(cap_strobe),
    .hist_shift(hist_shift), .wr_bank_sel(wr_bank_sel), .rd_bank_sel(rd_bank_sel),
    .card_addr(card_addr), .func_addr(func_addr), .bus_strobe(bus_strobe),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe)
  );

  function automatic logic [63:0] pat(input int i);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1) ^ 64'(i * 131);
  endfunction

  function automatic logic [7:0] expect_byte(input int b, input int addr);
    int n;
    int off;
    n = addr / 32;
    off = addr % 32;
    if (off >= 8) return 8'h00;
    return model[b][7 - n][off*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [63:0] m, input logic shift, input logic bank);
    mask_in = m; hist_shift = shift; wr_bank_sel = bank; cap_strobe = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0;
    if (shift) begin
      for (int k = 7; k > 0; k--) model[bank][k] = model[bank][k-1];
      model[bank][0] = m;
    end
  endtask

  // one-cycle bus cycle; returns what the port shows after the edge
  task automatic bus_cycle(input logic [5:0] card, input logic [7:0] addr,
                           input logic rd, output logic oe, output logic [7:0] d);
    card_addr = card; func_addr = addr; bus_rd = rd; bus_strobe = 1'b1;
    bus_wdata = 8'hFF;
    @(negedge clk);
    oe = bus_rdata_oe; d = bus_rdata;
    bus_strobe = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic select_read_bank(input logic b);
    rd_bank_sel = b;
    @(negedge clk);
  endtask

  task automatic sweep_bank(input int b, input string req);
    logic oe;
    logic [7:0] d;
    select_read_bank(b[0]);
    for (int a = 0; a < 256; a++) begin
      bus_cycle(CARD, 8'(a), 1'b1, oe, d);
      check({req, " oe"}, 32'(oe), 32'd1);
      check(req, 32'(d), 32'(expect_byte(b, a)));
    end
  endtask

  initial begin
    logic oe;
    logic [7:0] d;
    for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) model[b][k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 oe", 32'(bus_rdata_oe), 32'd0);
    sweep_bank(0, "R1 R4");

    // R2: fill bank A and bank B with distinct patterns
    for (int i = 0; i < 8; i++) capture(pat(i), 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) capture(pat(100 + i), 1'b1, 1'b1);
    sweep_bank(0, "R2 R4 R5 R6");
    sweep_bank(1, "R2 R4 R5 R6");

    // R5: explicit bit order, newest group 7 set 3 of bank A
    select_read_bank(1'b0);
    bus_cycle(CARD, 8'd227, 1'b1, oe, d);
    check("R5 bit0 is mask bit 24", 32'(d[0]), 32'(pat(7)[24]));
    check("R5 bit7 is mask bit 31", 32'(d[7]), 32'(pat(7)[31]));

    // R10: ninth capture drops oldest
    capture(pat(8), 1'b1, 1'b0);
    bus_cycle(CARD, 8'd0, 1'b1, oe, d);
    check("R10 oldest", 32'(d), 32'(pat(1)[7:0]));
    bus_cycle(CARD, 8'd230, 1'b1, oe, d);
    check("R10 newest", 32'(d), 32'(pat(8)[55:48]));

    // R3: capture with shifting off is ignored
    capture(64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0);
    capture(64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b1);
    sweep_bank(0, "R3");
    sweep_bank(1, "R3");

    // R7: wrong card and write cycles never drive, contents unchanged
    bus_cycle(CARD ^ 6'h01, 8'd224, 1'b1, oe, d);
    check("R7 wrong card oe", 32'(oe), 32'd0);
    bus_cycle(CARD, 8'd224, 1'b0, oe, d);
    check("R7 write oe", 32'(oe), 32'd0);
    for (int a = 0; a < 8; a++) bus_cycle(CARD, 8'(224 + a), 1'b0, oe, d);
    sweep_bank(0, "R7 unchanged");

    // R8: enable drops the cycle after strobe low
    bus_cycle(CARD, 8'd1, 1'b1, oe, d);
    check("R8 oe during", 32'(oe), 32'd1);
    @(negedge clk);
    check("R8 oe after", 32'(bus_rdata_oe), 32'd0);

    // R9: bank change while strobe held is deferred
    select_read_bank(1'b0);
    card_addr = CARD; func_addr = 8'd226; bus_rd = 1'b1; bus_strobe = 1'b1;
    @(negedge clk);
    check("R9 before", 32'(bus_rdata), 32'(expect_byte(0, 226)));
    rd_bank_sel = 1'b1;
    @(negedge clk);
    check("R9 held", 32'(bus_rdata), 32'(expect_byte(0, 226)));
    @(negedge clk);
    check("R9 still held", 32'(bus_rdata), 32'(expect_byte(0, 226)));
    bus_strobe = 1'b0;
    @(negedge clk);
    bus_strobe = 1'b1;
    @(negedge clk);
    check("R9 after swap", 32'(bus_rdata), 32'(expect_byte(1, 226)));
    bus_strobe = 1'b0; bus_rd = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule